// File: doc/BRIEF.md
# Pulse-Width Time Code Decoder

This block turns a stream of once-per-second tone pulses into a wall-clock reading of hours and minutes. An external detector supplies a synchronous flag that is high while the 100 Hz subcarrier tone is present. The local timekeeper supplies a strobe at the start of each second, and a timebase supplies a one-cycle tick every millisecond. For every second the block measures how many milliseconds of tone fall into three fixed windows after the strobe. From those three counts it grades the pulse as a zero, a one, a marker or an error.

After a minute reference it walks the frames of the minute. It checks where the markers and the fixed-zero slots fall, and it shifts the data bits into three 8-bit records. When the third marker arrives it validates the BCD minutes and hours, converts them to binary and subtracts a local time-zone offset modulo 24. It then emits a one-cycle time strobe. Any framing, grading or range failure instead emits a one-cycle resynchronise request and returns to acquisition. Results come at most once per minute and are plain pulses without back-pressure: the consumer must capture `time_hours` and `time_minutes` when it sees `time_valid`. Both values stay held until the next strobe.

Top module: `pwtc_decoder`

## Requirements
- R1: Tone is counted only in cycles where `ms_tick` is high and a second is open. A high `sec_strobe` opens a second and clears all three counts. Tick indexes 0..199 after the strobe feed the early count, 200..499 the middle count and 500..799 the late count. The second closes after index 799, and later ticks are ignored.
- R2: A pulse grades as error when the early count is 75 or less. Otherwise the middle and late counts decide, each judged as "long" when it exceeds 100. Neither long gives ZERO. Only the middle long gives ONE. Both long gives MARKER. Only the late long gives error.
- R3: Decoding starts only after an error-graded second (the silent minute reference) that directly follows a MARKER. No other sequence leaves acquisition.
- R4: Once decoding, the seconds form frames of ten slots numbered 1..10. Slot 5 must grade ZERO and slot 10 must grade MARKER. A MARKER in slots 1-4 or 6-9 is a violation. Any violation raises `resync_req` and returns to acquisition.
- R5: An error-graded second during decoding raises `resync_req` and returns to acquisition.
- R6: Each data slot (1-4, 6-9) shifts its record right by one bit and places the new bit in bit 7, with ONE as 1 and ZERO as 0. The first data bit of a frame thus ends in bit 0. Record 1 (frame 1) must be all zeros, otherwise `resync_req`.
- R7: Record 2 is minutes and record 3 is hours, each as BCD with units in bits 3:0 and tens in bits 7:4. Any of the following raises `resync_req` in place of a time: a digit above 9, minutes above 59, or hours above 23.
- R8: Once frame 3 ends with a valid MARKER and all checks pass, `time_valid` pulses for exactly one cycle. The binary minutes (0-59) appear on `time_minutes` and the corrected hours on `time_hours`, and both are held until the next pulse. Nothing after that marker affects the result.
- R9: The hours output equals the decoded hours minus `tz_hours`, modulo 24. A `tz_hours` value of 24-31 is first reduced by 24.
- R10: After reset both pulses are low and both value outputs are zero. `time_valid` and `resync_req` are never high in the same cycle, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle millisecond timebase tick |
| sec_strobe | input | 1 | Start-of-second strobe from the timekeeper |
| tone_on | input | 1 | High while the subcarrier tone is detected |
| tz_hours | input | 5 | Time-zone offset in hours, subtracted from decoded hours |
| time_valid | output | 1 | One-cycle strobe: a new time is on the value outputs |
| time_hours | output | 5 | Local hours 0-23, held between strobes |
| time_minutes | output | 6 | Minutes 0-59, held between strobes |
| resync_req | output | 1 | One-cycle request to re-acquire the minute |

## Verification
The hardest state to reach is a grading edge or framing fault deep inside a minute that is otherwise valid. The grade itself never leaves the block, so the bench can only see its effect thirty seconds later, as either a time or a resynchronise pulse. The bench builds whole minutes from a table of per-second tone lengths and then edits single entries. Those edits include counts one above each threshold, a tone split so that only the late window is long, a marker in a data slot, and a non-zero fifth slot. Each edited minute is predicted as either a time value or exactly one resync event. A further minute interleaves idle non-tick cycles that carry an inverted tone, which proves that only ticked cycles are counted.

// File: rtl/pwtc_pkg.sv
package pwtc_pkg;
  typedef enum logic [1:0] {
    PC_ZERO = 2'd0,
    PC_ONE  = 2'd1,
    PC_MARK = 2'd2,
    PC_ERR  = 2'd3
  } pulse_cls_t;

  localparam int FRAME_LEN  = 10;  // slots per frame
  localparam int ZERO_SLOT  = 5;   // fixed-zero slot inside a frame
  localparam int NREC       = 3;   // records needed for the time
  localparam int REC_W      = 8;   // data bits per record
  localparam int HR_W       = 5;
  localparam int MN_W       = 6;
  localparam int HOURS_DAY  = 24;
  localparam int MINS_HOUR  = 60;
endpackage

// File: rtl/pwtc_window_meter.sv
module pwtc_window_meter #(
  parameter int WIN0_END = 200,
  parameter int WIN1_END = 500,
  parameter int WIN2_END = 800,
  parameter int CW       = $clog2(WIN2_END + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_tick,
  input  logic          sec_strobe,
  input  logic          tone_on,
  output logic [CW-1:0] early_cnt,
  output logic [CW-1:0] mid_cnt,
  output logic [CW-1:0] late_cnt,
  output logic          meas_done
);
  localparam logic [CW-1:0] E0 = CW'(WIN0_END);
  localparam logic [CW-1:0] E1 = CW'(WIN1_END);
  localparam logic [CW-1:0] LAST = CW'(WIN2_END - 1);

  logic [CW-1:0] idx_q;
  logic          open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      open_q    <= 1'b0;
      early_cnt <= '0;
      mid_cnt   <= '0;
      late_cnt  <= '0;
      meas_done <= 1'b0;
    end else begin
      meas_done <= 1'b0;
      if (sec_strobe) begin
        idx_q     <= '0;
        open_q    <= 1'b1;
        early_cnt <= '0;
        mid_cnt   <= '0;
        late_cnt  <= '0;
      end else if (open_q && ms_tick) begin
        if (tone_on) begin
          if (idx_q < E0)      early_cnt <= early_cnt + CW'(1);
          else if (idx_q < E1) mid_cnt   <= mid_cnt + CW'(1);
          else                 late_cnt  <= late_cnt + CW'(1);
        end
        if (idx_q == LAST) begin
          open_q    <= 1'b0;
          meas_done <= 1'b1;
        end
        idx_q <= idx_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/pwtc_classifier.sv
module pwtc_classifier
  import pwtc_pkg::*;
#(
  parameter int CW         = 10,
  parameter int ZERO_FLOOR = 75,
  parameter int ONE_FLOOR  = 100,
  parameter int MARK_FLOOR = 100
) (
  input  logic [CW-1:0] early_cnt,
  input  logic [CW-1:0] mid_cnt,
  input  logic [CW-1:0] late_cnt,
  output pulse_cls_t    cls
);
  localparam logic [CW-1:0] ZF = CW'(ZERO_FLOOR);
  localparam logic [CW-1:0] OF = CW'(ONE_FLOOR);
  localparam logic [CW-1:0] MF = CW'(MARK_FLOOR);

  logic mid_long, late_long;

  always_comb begin
    mid_long  = mid_cnt > OF;
    late_long = late_cnt > MF;
    if (early_cnt <= ZF) begin
      cls = PC_ERR;
    end else begin
      unique case ({mid_long, late_long})
        2'b00:   cls = PC_ZERO;
        2'b10:   cls = PC_ONE;
        2'b11:   cls = PC_MARK;
        default: cls = PC_ERR;
      endcase
    end
  end
endmodule

// File: rtl/pwtc_frame_fsm.sv
module pwtc_frame_fsm
  import pwtc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cls_valid,
  input  pulse_cls_t            cls,
  output logic [NREC*REC_W-1:0] records,
  output logic                  frames_done,
  output logic                  abort
);
  localparam int PW = $clog2(FRAME_LEN + 1);
  localparam int FW = (NREC > 1) ? $clog2(NREC) : 1;
  localparam logic [PW-1:0] SLOT_END  = PW'(FRAME_LEN);
  localparam logic [PW-1:0] SLOT_ZERO = PW'(ZERO_SLOT);
  localparam logic [FW-1:0] LAST_REC  = FW'(NREC - 1);

  typedef enum logic {S_ACQ, S_DEC} st_t;

  st_t             st_q;
  logic [PW-1:0]   slot_q;
  logic [FW-1:0]   rec_idx_q;
  logic [REC_W-1:0] shift_q;
  logic            prev_mark_q;
  logic            store_now;

  assign store_now = cls_valid && (st_q == S_DEC) && (slot_q == SLOT_END) && (cls == PC_MARK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= S_ACQ;
      slot_q      <= PW'(1);
      rec_idx_q   <= '0;
      shift_q     <= '0;
      prev_mark_q <= 1'b0;
      frames_done <= 1'b0;
      abort       <= 1'b0;
    end else begin
      frames_done <= 1'b0;
      abort       <= 1'b0;
      if (cls_valid) begin
        prev_mark_q <= (cls == PC_MARK);
        unique case (st_q)
          S_ACQ: begin
            if (prev_mark_q && cls == PC_ERR) begin
              st_q      <= S_DEC;
              slot_q    <= PW'(1);
              rec_idx_q <= '0;
              shift_q   <= '0;
            end
          end
          S_DEC: begin
            if (cls == PC_ERR) begin
              abort <= 1'b1;
              st_q  <= S_ACQ;
            end else if (slot_q == SLOT_END) begin
              if (cls != PC_MARK) begin
                abort <= 1'b1;
                st_q  <= S_ACQ;
              end else begin
                slot_q  <= PW'(1);
                shift_q <= '0;
                if (rec_idx_q == LAST_REC) begin
                  frames_done <= 1'b1;
                  st_q        <= S_ACQ;
                end else begin
                  rec_idx_q <= rec_idx_q + FW'(1);
                end
              end
            end else if (slot_q == SLOT_ZERO) begin
              if (cls != PC_ZERO) begin
                abort <= 1'b1;
                st_q  <= S_ACQ;
              end else begin
                slot_q <= slot_q + PW'(1);
              end
            end else if (cls == PC_MARK) begin
              abort <= 1'b1;
              st_q  <= S_ACQ;
            end else begin
              shift_q <= {(cls == PC_ONE), shift_q[REC_W-1:1]};
              slot_q  <= slot_q + PW'(1);
            end
          end
          default: st_q <= S_ACQ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NREC; g++) begin : g_rec
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        records[g*REC_W +: REC_W] <= '0;
      end else if (store_now && rec_idx_q == FW'(g)) begin
        records[g*REC_W +: REC_W] <= shift_q;
      end
    end
  end
endmodule

// File: rtl/pwtc_time_convert.sv
module pwtc_time_convert
  import pwtc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic [NREC*REC_W-1:0] records,
  input  logic [HR_W-1:0]       tz_hours,
  output logic                  time_valid,
  output logic [HR_W-1:0]       time_hours,
  output logic [MN_W-1:0]       time_minutes,
  output logic                  reject
);
  localparam logic [HR_W-1:0] DAY_H  = HR_W'(HOURS_DAY);
  localparam logic [HR_W:0]   DAY_H1 = (HR_W + 1)'(HOURS_DAY);

  logic [REC_W-1:0] rec_lead, rec_min, rec_hr;
  logic [3:0]       mu, mt, hu, ht;
  logic             bad;
  logic [MN_W-1:0]  min_bin;
  logic [HR_W-1:0]  hr_bin, tz_eff, hr_loc;
  logic [HR_W:0]    hr_sum;

  always_comb begin
    rec_lead = records[0*REC_W +: REC_W];
    rec_min  = records[1*REC_W +: REC_W];
    rec_hr   = records[2*REC_W +: REC_W];
    mu = rec_min[3:0];
    mt = rec_min[7:4];
    hu = rec_hr[3:0];
    ht = rec_hr[7:4];
    bad = (rec_lead != '0) || (mu > 4'd9) || (mt > 4'd5) ||
          (hu > 4'd9) || (ht > 4'd2) || (ht == 4'd2 && hu > 4'd3);
    min_bin = MN_W'(mt) * MN_W'(10) + MN_W'(mu);
    hr_bin  = HR_W'(ht) * HR_W'(10) + HR_W'(hu);
    tz_eff  = (tz_hours >= DAY_H) ? tz_hours - DAY_H : tz_hours;
    hr_sum  = {1'b0, hr_bin} + DAY_H1 - {1'b0, tz_eff};
    hr_loc  = (hr_sum >= DAY_H1) ? HR_W'(hr_sum - DAY_H1) : HR_W'(hr_sum);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_valid   <= 1'b0;
      reject       <= 1'b0;
      time_hours   <= '0;
      time_minutes <= '0;
    end else begin
      time_valid <= go && !bad;
      reject     <= go && bad;
      if (go && !bad) begin
        time_hours   <= hr_loc;
        time_minutes <= min_bin;
      end
    end
  end
endmodule

// File: rtl/pwtc_decoder.sv
module pwtc_decoder
  import pwtc_pkg::*;
#(
  parameter int WIN0_END   = 200,
  parameter int WIN1_END   = 500,
  parameter int WIN2_END   = 800,
  parameter int ZERO_FLOOR = 75,
  parameter int ONE_FLOOR  = 100,
  parameter int MARK_FLOOR = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       sec_strobe,
  input  logic       tone_on,
  input  logic [4:0] tz_hours,
  output logic       time_valid,
  output logic [4:0] time_hours,
  output logic [5:0] time_minutes,
  output logic       resync_req
);
  localparam int CW = $clog2(WIN2_END + 1);

  logic [CW-1:0]           early_cnt, mid_cnt, late_cnt;
  logic                    meas_done;
  pulse_cls_t              cls;
  logic [NREC*REC_W-1:0]   records;
  logic                    frames_done, abort, reject;

  pwtc_window_meter #(
    .WIN0_END(WIN0_END), .WIN1_END(WIN1_END), .WIN2_END(WIN2_END), .CW(CW)
  ) meter_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .sec_strobe(sec_strobe),
    .tone_on(tone_on), .early_cnt(early_cnt), .mid_cnt(mid_cnt),
    .late_cnt(late_cnt), .meas_done(meas_done)
  );

  pwtc_classifier #(
    .CW(CW), .ZERO_FLOOR(ZERO_FLOOR), .ONE_FLOOR(ONE_FLOOR), .MARK_FLOOR(MARK_FLOOR)
  ) class_i (
    .early_cnt(early_cnt), .mid_cnt(mid_cnt), .late_cnt(late_cnt), .cls(cls)
  );

  pwtc_frame_fsm frame_i (
    .clk(clk), .rst_n(rst_n), .cls_valid(meas_done), .cls(cls),
    .records(records), .frames_done(frames_done), .abort(abort)
  );

  pwtc_time_convert conv_i (
    .clk(clk), .rst_n(rst_n), .go(frames_done), .records(records),
    .tz_hours(tz_hours), .time_valid(time_valid), .time_hours(time_hours),
    .time_minutes(time_minutes), .reject(reject)
  );

  assign resync_req = abort | reject;
endmodule

// File: rtl/pwtc_checker.sv
module pwtc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ms_tick,
  input logic       meas_done,
  input logic       time_valid,
  input logic [4:0] time_hours,
  input logic [5:0] time_minutes,
  input logic       resync_req
);
  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    time_valid |=> !time_valid);

  p_resync_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resync_req |=> !resync_req);

  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(time_valid && resync_req));

  p_hours_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    time_valid |-> time_hours < 5'd24);

  p_minutes_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    time_valid |-> time_minutes < 6'd60);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(time_hours) && $stable(time_minutes)) |-> time_valid);

  p_done_after_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |-> $past(ms_tick));

  p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |=> !meas_done);
endmodule

bind pwtc_decoder pwtc_checker chk_i (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .meas_done(meas_done),
  .time_valid(time_valid), .time_hours(time_hours),
  .time_minutes(time_minutes), .resync_req(resync_req)
);

// File: tb/pwtc_decoder_tb_top.sv
`timescale 1ns/1ps
module pwtc_decoder_tb_top;
  localparam int SEC_TICKS = 90;
  localparam int ZL = 20, OL = 50, ML = 80;
  localparam int WD_CYCLES = 190000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, ms_tick, sec_strobe, tone_on;
  logic [4:0] tz_hours;
  logic       time_valid, resync_req;
  logic [4:0] time_hours;
  logic [5:0] time_minutes;

  pwtc_decoder #(
    .WIN0_END(20), .WIN1_END(50), .WIN2_END(80),
    .ZERO_FLOOR(7), .ONE_FLOOR(10), .MARK_FLOOR(10)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .sec_strobe(sec_strobe),
    .tone_on(tone_on), .tz_hours(tz_hours), .time_valid(time_valid),
    .time_hours(time_hours), .time_minutes(time_minutes), .resync_req(resync_req)
  );

  int checks = 0, fails = 0;
  bit wd_fired = 0;

  typedef struct {
    bit    is_time;
    int    h;
    int    m;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  int lens[30];
  int gss[30];
  int ges[30];

  task automatic do_second(int len, int gs, int ge, bit gap);
    bit v;
    @(negedge clk);
    sec_strobe = 1'b1; ms_tick = 1'b0; tone_on = 1'b0;
    @(negedge clk);
    sec_strobe = 1'b0;
    for (int k = 0; k < SEC_TICKS; k++) begin
      v = (k < len) && !(k >= gs && k < ge);
      if (gap) begin
        ms_tick = 1'b0; tone_on = !v;
        @(negedge clk);
      end
      ms_tick = 1'b1; tone_on = v;
      @(negedge clk);
    end
    ms_tick = 1'b0; tone_on = 1'b0;
  endtask

  task automatic fill(int r1, int r2, int r3, int zl, int ol, int ml);
    int rec, idx, b;
    for (int f = 0; f < 3; f++) begin
      rec = (f == 0) ? r1 : (f == 1) ? r2 : r3;
      for (int p = 1; p <= 10; p++) begin
        idx = f * 10 + p - 1;
        gss[idx] = 0; ges[idx] = 0;
        if (p == 5)       lens[idx] = zl;
        else if (p == 10) lens[idx] = ml;
        else begin
          b = (p < 5) ? p - 1 : p - 2;
          lens[idx] = rec[b] ? ol : zl;
        end
      end
    end
  endtask

  task automatic play(bit lead, bit gap);
    do_second(lead ? ML : ZL, 0, 0, gap);
    do_second(0, 0, 0, gap);
    for (int i = 0; i < 30; i++) do_second(lens[i], gss[i], ges[i], gap);
  endtask

  task automatic exp_time(int h, int m, string tag);
    exp_t e;
    e.is_time = 1; e.h = h; e.m = m; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic exp_resync(string tag);
    exp_t e;
    e.is_time = 0; e.h = 0; e.m = 0; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (time_valid || resync_req)) begin
      exp_t e;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected event: actual valid=%0d resync=%0d expected none",
                 time_valid, resync_req);
      end else begin
        e = exp_q.pop_front();
        if (e.is_time) begin
          if (!time_valid || time_hours != e.h[4:0] || time_minutes != e.m[5:0]) begin
            fails++;
            $display("FAIL %s: actual valid=%0d %0d:%0d expected time %0d:%0d",
                     e.tag, time_valid, time_hours, time_minutes, e.h, e.m);
          end
        end else if (!resync_req) begin
          fails++;
          $display("FAIL %s: actual valid=%0d %0d:%0d expected resync",
                   e.tag, time_valid, time_hours, time_minutes);
        end
      end
    end
  end

  task automatic scenarios();
    // R6 R7 R8: plain minute
    tz_hours = 5'd0; fill(0, 'h39, 'h21, ZL, OL, ML);
    exp_time(21, 39, "R8 plain 21:39"); play(1, 0);
    // R9: offset wraps below zero
    tz_hours = 5'd8; fill(0, 'h07, 'h05, ZL, OL, ML);
    exp_time(21, 7, "R9 wrap 05-8"); play(1, 0);
    // R9 R7: top of range
    tz_hours = 5'd23; fill(0, 'h59, 'h23, ZL, OL, ML);
    exp_time(0, 59, "R9 23-23 at 59 min"); play(1, 0);
    // R9: offset above 23 reduced by 24
    tz_hours = 5'd26; fill(0, 'h00, 'h01, ZL, OL, ML);
    exp_time(23, 0, "R9 offset 26"); play(1, 0);
    // R2: counts one past each floor
    tz_hours = 5'd0; fill(0, 'h45, 'h12, 8, 31, 61);
    exp_time(12, 45, "R2 thresholds low"); play(1, 0);
    // R2: middle count exactly at floor still ZERO
    tz_hours = 5'd3; fill(0, 'h58, 'h09, 30, 31, 61);
    exp_time(6, 58, "R2 middle at floor"); play(1, 0);
    // R1: idle cycles with inverted tone, tone past window end
    tz_hours = 5'd5; fill(0, 'h17, 'h13, ZL, OL, SEC_TICKS);
    exp_time(8, 17, "R1 tick gating"); play(1, 1);
    // R4: fifth slot of frame 2 is ONE
    tz_hours = 5'd0; fill(0, 'h39, 'h21, ZL, OL, ML); lens[14] = OL;
    exp_resync("R4 fifth slot"); play(1, 0);
    // R4: marker in data slot 3 of frame 3
    fill(0, 'h39, 'h21, ZL, OL, ML); lens[22] = ML;
    exp_resync("R4 marker in data slot"); play(1, 0);
    // R4: slot 10 of frame 1 not a marker
    fill(0, 'h39, 'h21, ZL, OL, ML); lens[9] = ZL;
    exp_resync("R4 missing marker"); play(1, 0);
    // R5 R2: early count at floor is error
    fill(0, 'h39, 'h21, ZL, OL, ML); lens[12] = 7;
    exp_resync("R5 short early"); play(1, 0);
    // R5 R2: only late window long
    fill(0, 'h39, 'h21, ZL, OL, ML); lens[16] = ML; gss[16] = 20; ges[16] = 50;
    exp_resync("R5 late only"); play(1, 0);
    // R6: record 1 non-zero
    fill('h04, 'h39, 'h21, ZL, OL, ML);
    exp_resync("R6 record1 nonzero"); play(1, 0);
    // R7: minutes 60, units digit 10, hours 24
    fill(0, 'h60, 'h21, ZL, OL, ML);
    exp_resync("R7 minutes 60"); play(1, 0);
    fill(0, 'h2A, 'h21, ZL, OL, ML);
    exp_resync("R7 units digit"); play(1, 0);
    fill(0, 'h39, 'h24, ZL, OL, ML);
    exp_resync("R7 hours 24"); play(1, 0);
    // R3: silent second not after a marker does not start decoding
    fill(0, 'h33, 'h11, ZL, OL, ML); play(0, 0);
    exp_time(11, 33, "R3 acquisition"); play(1, 0);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; ms_tick = 1'b0; sec_strobe = 1'b0; tone_on = 1'b0; tz_hours = 5'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (time_valid || resync_req || time_hours != 0 || time_minutes != 0) begin
      fails++;
      $display("FAIL R10 reset: actual v=%0d r=%0d %0d:%0d expected 0 0 0:0",
               time_valid, resync_req, time_hours, time_minutes);
    end
    fork
      scenarios();
      begin
        repeat (WD_CYCLES) @(posedge clk);
        wd_fired = 1;
      end
    join_any
    disable fork;
    if (wd_fired) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R8 pending events: actual %0d expected 0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule